// File: doc/BRIEF.md
# Receive Byte Queue with Character Timeout

This block is the receive side storage of a 16550-style serial port. A deserializer hands it one byte per strobe, or a line-break event. The host pops bytes one at a time. In queued mode the bytes sit in a 16-entry first-in first-out store. In direct mode a single holding register replaces the store. The block keeps the data-ready, overrun and break status flags. It exposes the occupancy count, and it raises a trigger indication when the count reaches a programmable level.

A character-timeout engine watches the queue. Its limit is four frame times, counted in bit-period ticks. The frame length comes from the current line format: one start bit, five to eight data bits, an optional parity bit and one or two stop bits. The engine is a two-state machine. IDLE moves to RUN on a restart, which is any received byte or any read that leaves the queue non-empty. RUN moves back to IDLE on a stop, which is a flush or a read that empties the queue. RUN also moves to IDLE on expiry. On expiry the pending-timeout flag is set, but only if the queue still holds data. A restart while in RUN stays in RUN and clears the tick count.

The host interface has three control strobes: a queue-control write, a data read, and a status read. The status read clears overrun and break.

Top module: `rx_byte_queue`

## Requirements
- R1: A control write with `ctl_fifo_en`=1 loads the trigger code `ctl_trig`. The codes map as 00→1, 01→4, 10→8 and 11→14 bytes. In queued mode `trig_hit` is 1 exactly when `level` is at least the trigger count.
- R2: In queued mode, a byte that arrives while 16 bytes are stored and no read takes place is discarded. The stored bytes are unchanged, `level` stays 16 and `overrun` is set.
- R3: A break event stores a byte of value 0x00 and sets both `brk` and `data_ready`.
- R4: The timeout limit is 4 × frame length in `bit_tick` pulses. Counting starts after each received byte, and after each read that leaves the queue non-empty. `timeout_pend` is set on the last tick only if the queue is non-empty at that point.
- R5: In queued mode any data read clears `timeout_pend`. When a read empties the queue, `data_ready` and `brk` clear. A read of an empty queue returns 0x00.
- R6: A control write with `ctl_rx_clear`=1 empties the queue and clears `data_ready`, `brk` and `timeout_pend`. A write whose `ctl_fifo_en` differs from the current mode has the same flush effect.
- R7: Frame length is 1 + (5 + `fmt`[1:0]) + `fmt`[3] + (`fmt`[2] ? 2 : 1) bits. The code `fmt`=0x0 therefore gives 28 ticks, and 0xF gives 48 ticks.
- R8: In direct mode, a byte arriving while `data_ready` is 1 (with no read in that cycle) overwrites the holding register and sets `overrun`. A read clears `data_ready`. `trig_hit` follows `data_ready` in this mode.
- R9: A status read (`stat_rd`) clears `overrun` and `brk`. A set event in the same cycle takes priority over the clear.
- R10: After reset the block is in direct mode with `level`=0 and every flag low. `rd_data` reads 0x00.
- R11: When the queue is full and a read and a new byte fall in the same cycle, the byte is accepted. `level` stays 16 and `overrun` stays clear.
- R12: Bytes leave in arrival order, and `level` counts the stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Line-break event strobe (wins over rx_valid) |
| bit_tick | input | 1 | One pulse per bit period |
| fmt | input | 4 | Line format: [1:0] data bits − 5, [2] two stop bits, [3] parity on |
| ctl_wr | input | 1 | Queue-control write strobe |
| ctl_fifo_en | input | 1 | Written mode: 1 queued, 0 direct |
| ctl_rx_clear | input | 1 | Written flush request |
| ctl_trig | input | 2 | Written trigger code |
| rd_en | input | 1 | Data read strobe; pops at the clock edge |
| stat_rd | input | 1 | Status read strobe; clears overrun and break |
| rd_data | output | 8 | Byte presented to the host |
| level | output | 5 | Stored byte count |
| data_ready | output | 1 | Data available |
| overrun | output | 1 | A byte was lost or overwritten |
| brk | output | 1 | Break received |
| trig_hit | output | 1 | Trigger level reached |
| timeout_pend | output | 1 | Character timeout pending |

## Verification
The interesting collision is a host pop and an arriving byte landing in the same edge while the queue is full. Draining first lets the byte in, so it must neither be dropped nor flag an overrun. The bench fills all 16 entries and clears the status. It then raises `rd_en` and `rx_valid` together. It checks that the popped value is the oldest byte, that `level` stays 16 and `overrun` stays low, and that the new byte comes out last. A second collision, a read arriving against the timer's final tick, is covered by the rule that a read always clears the pending flag.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int BYTE_W    = 8;
    localparam int DEPTH     = 16;
    localparam int CNT_W     = $clog2(DEPTH + 1);
    localparam int TMO_CHARS = 4;
    localparam int FRAME_W   = 4;
    localparam int LIMIT_W   = 6;

    typedef enum logic {
        TMO_IDLE = 1'b0,
        TMO_RUN  = 1'b1
    } tmo_state_e;

    function automatic logic [CNT_W-1:0] trig_bytes(input logic [1:0] code);
        logic [CNT_W-1:0] n;
        unique case (code)
            2'b00: n = CNT_W'(1);
            2'b01: n = CNT_W'(4);
            2'b10: n = CNT_W'(8);
            default: n = CNT_W'(14);
        endcase
        return n;
    endfunction
endpackage

// File: rtl/rxq_frame.sv
module rxq_frame #(
    parameter int FRAME_W = 4,
    parameter int LIMIT_W = 6,
    parameter int CHARS   = 4
) (
    input  logic [3:0]         fmt,
    output logic [LIMIT_W-1:0] limit
);
    logic [FRAME_W-1:0] bits;

    always_comb begin
        bits  = FRAME_W'(6) + FRAME_W'(fmt[1:0]) + FRAME_W'(fmt[3])
              + (fmt[2] ? FRAME_W'(2) : FRAME_W'(1));
        limit = LIMIT_W'(bits) * LIMIT_W'(CHARS);
    end
endmodule

// File: rtl/rxq_timer.sv
module rxq_timer
    import rxq_pkg::*;
#(
    parameter int LIMIT_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [LIMIT_W-1:0] limit,
    input  logic               restart,
    input  logic               stop,
    input  logic               clear,
    input  logic               has_data,
    output logic               pend
);
    tmo_state_e         state_q, state_d;
    logic [LIMIT_W-1:0] cnt_q, cnt_d;
    logic               pend_q;
    logic               expire;

    // output process
    always_comb begin
        expire = (state_q == TMO_RUN) && tick && !restart && !stop &&
                 (({1'b0, cnt_q} + 1'b1) >= {1'b0, limit});
        pend   = pend_q;
    end

    // next-state process
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TMO_IDLE: begin
                if (restart) begin
                    state_d = TMO_RUN;
                    cnt_d   = '0;
                end
            end
            TMO_RUN: begin
                if (stop) begin
                    state_d = TMO_IDLE;
                end else if (restart) begin
                    cnt_d = '0;
                end else if (expire) begin
                    state_d = TMO_IDLE;
                end else if (tick) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = TMO_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMO_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  pend_q <= 1'b0;
        else if (clear)              pend_q <= 1'b0;
        else if (expire && has_data) pend_q <= 1'b1;
    end
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else if (flush) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            count_q <= count_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign dout  = mem[rd_ptr];
    assign count = count_q;
endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue
    import rxq_pkg::*;
#(
    parameter int W     = BYTE_W,
    parameter int QD    = DEPTH,
    parameter int QCW   = $clog2(QD + 1),
    parameter int LIM_W = LIMIT_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rx_valid,
    input  logic [W-1:0]   rx_data,
    input  logic           rx_break,
    input  logic           bit_tick,
    input  logic [3:0]     fmt,
    input  logic           ctl_wr,
    input  logic           ctl_fifo_en,
    input  logic           ctl_rx_clear,
    input  logic [1:0]     ctl_trig,
    input  logic           rd_en,
    input  logic           stat_rd,
    output logic [W-1:0]   rd_data,
    output logic [QCW-1:0] level,
    output logic           data_ready,
    output logic           overrun,
    output logic           brk,
    output logic           trig_hit,
    output logic           timeout_pend
);
    logic             fifo_en;
    logic [1:0]       trig_code;
    logic [W-1:0]     hold_q;
    logic             hold_valid;
    logic             ovr_q, brk_q;
    logic [QCW-1:0]   count;
    logic [W-1:0]     q_dout;
    logic [LIM_W-1:0] limit;

    logic             rx_flush, byte_in, push, pop, full, drop;
    logic             direct_ovr, empties, restart, stop;
    logic [W-1:0]     byte_val;
    logic [QCW-1:0]   count_after;

    always_comb begin
        rx_flush    = ctl_wr && (ctl_rx_clear || (ctl_fifo_en != fifo_en));
        byte_in     = (rx_valid || rx_break) && !rx_flush;
        byte_val    = rx_break ? '0 : rx_data;
        pop         = fifo_en && rd_en && (count != '0) && !rx_flush;
        full        = (count == QCW'(QD));
        push        = fifo_en && byte_in && (!full || pop);
        drop        = fifo_en && byte_in && full && !pop;
        direct_ovr  = !fifo_en && byte_in && hold_valid && !rd_en;
        count_after = count + QCW'(push) - QCW'(pop);
        empties     = fifo_en ? (rd_en && count_after == '0) : rd_en;
        restart     = fifo_en && !rx_flush && (byte_in || (rd_en && count_after != '0));
        stop        = rx_flush || (fifo_en && rd_en && count_after == '0 && !byte_in);
    end

    rxq_store #(.W(W), .DEPTH(QD), .CNT_W(QCW)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(push), .pop(pop),
        .din(byte_val), .dout(q_dout), .count(count)
    );

    rxq_frame #(.FRAME_W(FRAME_W), .LIMIT_W(LIM_W), .CHARS(TMO_CHARS)) u_frame (
        .fmt(fmt), .limit(limit)
    );

    rxq_timer #(.LIMIT_W(LIM_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(bit_tick), .limit(limit),
        .restart(restart), .stop(stop),
        .clear(rx_flush || (fifo_en && rd_en)),
        .has_data(count != '0), .pend(timeout_pend)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_en   <= 1'b0;
            trig_code <= 2'b00;
        end else if (ctl_wr) begin
            fifo_en <= ctl_fifo_en;
            if (ctl_fifo_en) trig_code <= ctl_trig;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q     <= '0;
            hold_valid <= 1'b0;
        end else if (rx_flush) begin
            hold_valid <= 1'b0;
        end else if (!fifo_en) begin
            if (byte_in) begin
                hold_q     <= byte_val;
                hold_valid <= 1'b1;
            end else if (rd_en) begin
                hold_valid <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   ovr_q <= 1'b0;
        else if (drop || direct_ovr)  ovr_q <= 1'b1;
        else if (stat_rd)             ovr_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    brk_q <= 1'b0;
        else if (rx_flush)             brk_q <= 1'b0;
        else if (rx_break)             brk_q <= 1'b1;
        else if (stat_rd || empties)   brk_q <= 1'b0;
    end

    always_comb begin
        level      = count;
        overrun    = ovr_q;
        brk        = brk_q;
        data_ready = fifo_en ? (count != '0) : hold_valid;
        trig_hit   = fifo_en ? (count >= trig_bytes(trig_code)) : hold_valid;
        rd_data    = fifo_en ? ((count != '0) ? q_dout : '0) : hold_q;
    end
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int QD  = 16,
    parameter int QCW = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           rx_valid,
    input logic           rx_break,
    input logic           rd_en,
    input logic           ctl_wr,
    input logic           ctl_rx_clear,
    input logic           fifo_en,
    input logic [QCW-1:0] level,
    input logic           overrun,
    input logic           brk,
    input logic           data_ready,
    input logic           timeout_pend
);
    // R12
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= QCW'(QD));

    // R2
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_en && level == QCW'(QD) && rx_valid && !rx_break && !rd_en && !ctl_wr
        |=> overrun && level == QCW'(QD));

    // R3
    break_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_break && !ctl_wr |=> brk && data_ready);

    // R5
    read_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_en && rd_en |=> !timeout_pend);

    // R6
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && ctl_rx_clear |=> level == '0 && !data_ready && !brk && !timeout_pend);

    // R4
    pend_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_pend) |-> level != '0);
endmodule

bind rx_byte_queue rxq_checker #(.QD(QD), .QCW(QCW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_break(rx_break),
    .rd_en(rd_en), .ctl_wr(ctl_wr), .ctl_rx_clear(ctl_rx_clear),
    .fifo_en(fifo_en), .level(level), .overrun(overrun), .brk(brk),
    .data_ready(data_ready), .timeout_pend(timeout_pend)
);

// File: tb/rx_byte_queue_test.sv
module rx_byte_queue_test;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0, rx_break = 1'b0, bit_tick = 1'b0;
    logic [7:0] rx_data = '0;
    logic [3:0] fmt = '0;
    logic       ctl_wr = 1'b0, ctl_fifo_en = 1'b0, ctl_rx_clear = 1'b0;
    logic [1:0] ctl_trig = '0;
    logic       rd_en = 1'b0, stat_rd = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] level;
    logic       data_ready, overrun, brk, trig_hit, timeout_pend;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(PERIOD/2) clk = ~clk;

    rx_byte_queue uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_break(rx_break), .bit_tick(bit_tick), .fmt(fmt), .ctl_wr(ctl_wr),
        .ctl_fifo_en(ctl_fifo_en), .ctl_rx_clear(ctl_rx_clear), .ctl_trig(ctl_trig),
        .rd_en(rd_en), .stat_rd(stat_rd), .rd_data(rd_data), .level(level),
        .data_ready(data_ready), .overrun(overrun), .brk(brk), .trig_hit(trig_hit),
        .timeout_pend(timeout_pend)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic ctl(input bit en, input bit clr, input logic [1:0] tr);
        ctl_wr = 1; ctl_fifo_en = en; ctl_rx_clear = clr; ctl_trig = tr;
        step();
        ctl_wr = 0; ctl_rx_clear = 0;
    endtask

    task automatic push(input logic [7:0] b);
        rx_valid = 1; rx_data = b;
        step();
        rx_valid = 0;
    endtask

    task automatic pop_chk(input string tag, input logic [7:0] exp);
        rd_en = 1;
        chk(tag, rd_data, exp);
        step();
        rd_en = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1;
            step();
        end
        bit_tick = 0;
    endtask

    task automatic clr_status();
        stat_rd = 1;
        step();
        stat_rd = 0;
    endtask

    task automatic t_reset();
        chk("R10 level", level, 0);
        chk("R10 data_ready", data_ready, 0);
        chk("R10 overrun", overrun, 0);
        chk("R10 brk", brk, 0);
        chk("R10 pend", timeout_pend, 0);
        chk("R10 rd_data", rd_data, 0);
    endtask

    task automatic t_order();
        ctl(1, 1, 2'b00);
        for (int i = 0; i < 5; i++) push(8'h40 + 8'(i));
        chk("R12 level", level, 5);
        for (int i = 0; i < 5; i++) pop_chk("R12 order", 8'h40 + 8'(i));
        chk("R5 empty dr", data_ready, 0);
        pop_chk("R5 empty read zero", 8'h00);
    endtask

    task automatic t_trigger();
        ctl(1, 1, 2'b01);
        for (int i = 0; i < 3; i++) push(8'h01);
        chk("R1 4 below", trig_hit, 0);
        push(8'h01);
        chk("R1 4 at", trig_hit, 1);
        ctl(1, 1, 2'b10);
        for (int i = 0; i < 7; i++) push(8'h02);
        chk("R1 8 below", trig_hit, 0);
        push(8'h02);
        chk("R1 8 at", trig_hit, 1);
        ctl(1, 1, 2'b11);
        for (int i = 0; i < 13; i++) push(8'h03);
        chk("R1 14 below", trig_hit, 0);
        push(8'h03);
        chk("R1 14 at", trig_hit, 1);
        ctl(1, 1, 2'b00);
        chk("R1 1 empty", trig_hit, 0);
        push(8'h04);
        chk("R1 1 at", trig_hit, 1);
    endtask

    task automatic t_overrun();
        ctl(1, 1, 2'b00);
        clr_status();
        for (int i = 0; i < 16; i++) push(8'h10 + 8'(i));
        chk("R2 full level", level, 16);
        chk("R2 no ovr yet", overrun, 0);
        push(8'hEE);
        chk("R2 ovr set", overrun, 1);
        chk("R2 level kept", level, 16);
        for (int i = 0; i < 16; i++) pop_chk("R2 contents kept", 8'h10 + 8'(i));
        chk("R2 drained", level, 0);
        clr_status();
        chk("R9 ovr cleared", overrun, 0);
    endtask

    task automatic t_same_cycle();
        ctl(1, 1, 2'b00);
        clr_status();
        for (int i = 0; i < 16; i++) push(8'h20 + 8'(i));
        rd_en = 1; rx_valid = 1; rx_data = 8'h99;
        chk("R11 popped oldest", rd_data, 8'h20);
        step();
        rd_en = 0; rx_valid = 0;
        chk("R11 level", level, 16);
        chk("R11 no ovr", overrun, 0);
        for (int i = 1; i < 16; i++) pop_chk("R11 order", 8'h20 + 8'(i));
        pop_chk("R11 last byte", 8'h99);
    endtask

    task automatic t_break();
        ctl(1, 1, 2'b00);
        rx_break = 1; rx_data = 8'h77; rx_valid = 1;
        step();
        rx_break = 0; rx_valid = 0;
        chk("R3 brk", brk, 1);
        chk("R3 dr", data_ready, 1);
        chk("R3 level", level, 1);
        chk("R3 zero byte", rd_data, 0);
        clr_status();
        chk("R9 brk cleared", brk, 0);
        chk("R9 dr kept", data_ready, 1);
        ctl(1, 1, 2'b00);
        rx_break = 1;
        step();
        rx_break = 0;
        pop_chk("R3 break byte", 8'h00);
        chk("R5 brk clears on empty", brk, 0);
        chk("R5 dr clears on empty", data_ready, 0);
    endtask

    task automatic t_timeout();
        ctl(1, 1, 2'b00);
        fmt = 4'h0;
        push(8'hA1);
        ticks(27);
        chk("R7 fmt0 before", timeout_pend, 0);
        ticks(1);
        chk("R4 fmt0 expiry", timeout_pend, 1);
        pop_chk("R4 data", 8'hA1);
        chk("R5 read clears pend", timeout_pend, 0);
        fmt = 4'hF;
        push(8'hB1);
        push(8'hB2);
        ticks(47);
        chk("R7 fmtF before", timeout_pend, 0);
        ticks(1);
        chk("R7 fmtF expiry", timeout_pend, 1);
        pop_chk("R4 first", 8'hB1);
        chk("R5 pend cleared", timeout_pend, 0);
        ticks(47);
        chk("R4 rearm before", timeout_pend, 0);
        ticks(1);
        chk("R4 rearm after read", timeout_pend, 1);
        pop_chk("R4 second", 8'hB2);
        ticks(60);
        chk("R4 empty no flag", timeout_pend, 0);
        fmt = 4'h0;
    endtask

    task automatic t_flush();
        ctl(1, 1, 2'b00);
        push(8'h11); push(8'h12); push(8'h13);
        ticks(28);
        chk("R4 pend before flush", timeout_pend, 1);
        ctl(1, 1, 2'b00);
        chk("R6 level", level, 0);
        chk("R6 dr", data_ready, 0);
        chk("R6 pend", timeout_pend, 0);
        push(8'h21); push(8'h22);
        ctl(0, 0, 2'b00);
        chk("R6 mode change dr", data_ready, 0);
        ctl(1, 0, 2'b00);
        chk("R6 mode change level", level, 0);
    endtask

    task automatic t_holding();
        ctl(0, 0, 2'b00);
        clr_status();
        push(8'hA5);
        chk("R8 dr", data_ready, 1);
        chk("R8 trig follows dr", trig_hit, 1);
        chk("R8 data", rd_data, 8'hA5);
        chk("R8 no ovr", overrun, 0);
        push(8'h3C);
        chk("R8 ovr", overrun, 1);
        chk("R8 overwrite", rd_data, 8'h3C);
        chk("R8 level stays 0", level, 0);
        pop_chk("R8 read", 8'h3C);
        chk("R8 dr cleared", data_ready, 0);
        stat_rd = 1; push(8'h55); stat_rd = 0;
        chk("R9 no new ovr", overrun, 0);
    endtask

    initial begin
        #(200000 * PERIOD);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1;
        step();
        t_reset();
        t_order();
        t_trigger();
        t_overrun();
        t_same_cycle();
        t_break();
        t_timeout();
        t_flush();
        t_holding();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule